// File: doc/BRIEF.md
# Priority Pin Crossbar

The block hands a bank of 32 I/O pins, four ports of eight, to a fixed list of peripheral signal lanes. Each lane has a fixed rank. A lane that is switched on takes the next free pin, counting upward from pin 0. Whatever pins are left over act as plain GPIO and drive the value held in their port data latch. No pin number is fixed in advance. If software enables more lanes, every lower-ranked lane moves to a higher pin.

Three configuration words plus a global enable bit decide which lanes take part. The pin allocation is pure combinational logic, evaluated from the current configuration. The pad output value and pad output enable are registered, so a new configuration reaches the pads one clock after it is applied. Peripheral inputs are taken from the pad at the lane's assigned pin. The pad levels are always returned unchanged on a readback bus.

When the enabled lanes need more pins than the bank holds, the excess lanes are left unconnected and a sticky overflow flag is raised. The block has no data stream, so every pin is a plain level signal with no valid/ready handshake and no back-pressure.

Top module: `pin_crossbar`

## Requirements
- R1: Lane decode. There are 31 lanes, in rank order 0..30.
  - cfg_a[0] enables lanes 0-1 (UART A).
  - cfg_a[1] enables lanes 2-5 (SPI).
  - cfg_a[2] enables lanes 6-7 (two-wire bus).
  - cfg_a[3] enables lanes 8-9 (UART B).
  - cfg_a[6:4] = n enables the first min(n,6) of lanes 10-15 (capture/PWM). A value of 7 is treated as 6.
  - cfg_b[0] enables lanes 16-17 (comparator outputs).
  - cfg_b[1] through cfg_b[6] enable single lanes 18 through 23 in turn: timer 0, ext int 0, timer 1, ext int 1, clock out, conversion start 0.
  - cfg_c[5:0] enable single lanes 24-29 (timer 2/3/4 input and reload pairs).
  - cfg_c[6] enables lane 30 (conversion start 2).
- R2: With xbar_en high, an enabled lane k is assigned pin number P = the count of enabled lanes with a rank below k. The lane is connected when P is less than the pin count.
- R3: With xbar_en high, a pin owned by no connected lane drives pad_out = gpio_latch at that pin, with pad_oe = 1.
- R4: With xbar_en low, every pin has pad_out = 0 and pad_oe = 0, and every lane_in bit is 1, whatever the lane enables say.
- R5: pad_out and pad_oe are registered. Both are 0 during reset. They change only on the clock edge after an input change.
- R6: A pin owned by connected lane k drives pad_out = lane_out[k] and pad_oe = lane_oe[k].
- R7: lane_in[k] equals pad_in at lane k's assigned pin when the lane is connected. Otherwise it is 1. This path is combinational.
- R8: port_rd always equals pad_in, whatever the assignment.
- R9: An enabled lane whose assigned pin number would reach the pin count is left unconnected. ovf_flag goes to 1 on the next clock edge and stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_a | input | 7 | Serial, bus and capture lane enables (R1) |
| cfg_b | input | 7 | Comparator, timer, interrupt and clock lane enables (R1) |
| cfg_c | input | 7 | Timer pair and conversion start 2 lane enables (R1) |
| xbar_en | input | 1 | Global crossbar enable |
| lane_out | input | 31 | Output value per lane |
| lane_oe | input | 31 | Output enable per lane |
| lane_in | output | 31 | Pad value routed to each lane, 1 when unassigned |
| gpio_latch | input | 32 | Port data latches for GPIO pins |
| pad_in | input | 32 | Pad levels |
| pad_out | output | 32 | Registered pad output value |
| pad_oe | output | 32 | Registered pad output enable |
| port_rd | output | 32 | Pad level readback |
| ovf_flag | output | 1 | Sticky pin overflow flag |

## Verification
A configuration change and a change in lane data can land in the same cycle. The outputs registered at the next edge must then reflect both together: the new pin packing and the new lane values. The bench forces this by changing cfg words, lane_out, lane_oe and gpio_latch at the same negedge, in directed steps and in a random run. A behavioural model checks pad_out and pad_oe on the following cycle, and checks before the edge that the old values still hold. A second pairing is overflow together with a global disable. A second instance with 16 pins is driven past its capacity while xbar_en toggles. This shows that the sticky flag sets only while the crossbar is enabled, and that it then stays set.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  localparam int NLANES  = 31;
  localparam int PCA_MAX = 6;
  // lane ranks, lowest number wins the lowest pin
  localparam int L_UA     = 0;
  localparam int L_SPI    = 2;
  localparam int L_TWB    = 6;
  localparam int L_UB     = 8;
  localparam int L_PCA    = 10;
  localparam int L_CMP    = 16;
  localparam int L_TM0    = 18;
  localparam int L_EI0    = 19;
  localparam int L_TM1    = 20;
  localparam int L_EI1    = 21;
  localparam int L_CKO    = 22;
  localparam int L_CS0    = 23;
  localparam int L_TPAIR  = 24;
  localparam int L_CS2    = 30;
endpackage

// File: rtl/xbar_lane_decode.sv
module xbar_lane_decode
  import xbar_pkg::*;
(
  input  logic [6:0]        cfg_a,
  input  logic [6:0]        cfg_b,
  input  logic [6:0]        cfg_c,
  output logic [NLANES-1:0] lane_en
);
  logic [2:0] pca_n;

  always_comb begin
    pca_n = (cfg_a[6:4] > 3'(PCA_MAX)) ? 3'(PCA_MAX) : cfg_a[6:4];
    lane_en = '0;
    lane_en[L_UA  +: 2] = {2{cfg_a[0]}};
    lane_en[L_SPI +: 4] = {4{cfg_a[1]}};
    lane_en[L_TWB +: 2] = {2{cfg_a[2]}};
    lane_en[L_UB  +: 2] = {2{cfg_a[3]}};
    for (int i = 0; i < PCA_MAX; i++) begin
      lane_en[L_PCA + i] = (3'(i) < pca_n);
    end
    lane_en[L_CMP +: 2] = {2{cfg_b[0]}};
    lane_en[L_TM0] = cfg_b[1];
    lane_en[L_EI0] = cfg_b[2];
    lane_en[L_TM1] = cfg_b[3];
    lane_en[L_EI1] = cfg_b[4];
    lane_en[L_CKO] = cfg_b[5];
    lane_en[L_CS0] = cfg_b[6];
    lane_en[L_TPAIR +: 6] = cfg_c[5:0];
    lane_en[L_CS2] = cfg_c[6];
  end
endmodule

// File: rtl/xbar_alloc.sv
module xbar_alloc
  import xbar_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int IW    = 6
) (
  input  logic              xbar_en,
  input  logic [NLANES-1:0] lane_en,
  output logic [IW-1:0]     idx [NLANES],
  output logic [NLANES-1:0] connected,
  output logic              overflow
);
  logic [IW-1:0] acc;

  // running sum of enabled higher-ranked lanes gives each lane its pin
  always_comb begin
    acc = '0;
    for (int k = 0; k < NLANES; k++) begin
      idx[k]       = acc;
      connected[k] = xbar_en && lane_en[k] && (int'(acc) < NPINS);
      acc          = acc + IW'(lane_en[k]);
    end
    overflow = xbar_en && (|(lane_en & ~connected));
  end
endmodule

// File: rtl/xbar_pad_mux.sv
module xbar_pad_mux
  import xbar_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int IW    = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xbar_en,
  input  logic [NLANES-1:0] connected,
  input  logic [IW-1:0]     idx [NLANES],
  input  logic [NLANES-1:0] lane_out,
  input  logic [NLANES-1:0] lane_oe,
  input  logic [NPINS-1:0]  gpio_latch,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe
);
  logic [NPINS-1:0] nxt_out, nxt_oe, own;

  always_comb begin
    nxt_out = gpio_latch;
    nxt_oe  = '1;
    own     = '0;
    for (int p = 0; p < NPINS; p++) begin
      for (int k = 0; k < NLANES; k++) begin
        if (connected[k] && (int'(idx[k]) == p)) begin
          nxt_out[p] = lane_out[k];
          nxt_oe[p]  = lane_oe[k];
          own[p]     = 1'b1;
        end
      end
    end
    if (!xbar_en) begin
      nxt_out = '0;
      nxt_oe  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pad_out <= '0;
      pad_oe  <= '0;
    end else begin
      pad_out <= nxt_out;
      pad_oe  <= nxt_oe;
    end
  end

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(xbar_en) |-> (pad_oe == '0 && pad_out == '0)); // R4

  AST_PIN_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(own) == $countones(connected)); // R2
endmodule

// File: rtl/xbar_in_route.sv
module xbar_in_route
  import xbar_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int IW    = 6
) (
  input  logic [NLANES-1:0] connected,
  input  logic [IW-1:0]     idx [NLANES],
  input  logic [NPINS-1:0]  pad_in,
  output logic [NLANES-1:0] lane_in
);
  always_comb begin
    lane_in = '1;
    for (int k = 0; k < NLANES; k++) begin
      for (int p = 0; p < NPINS; p++) begin
        if (connected[k] && (int'(idx[k]) == p)) lane_in[k] = pad_in[p];
      end
    end
  end
endmodule

// File: rtl/pin_crossbar.sv
module pin_crossbar
  import xbar_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int PORT_W    = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [6:0]                  cfg_a,
  input  logic [6:0]                  cfg_b,
  input  logic [6:0]                  cfg_c,
  input  logic                        xbar_en,
  input  logic [NLANES-1:0]           lane_out,
  input  logic [NLANES-1:0]           lane_oe,
  output logic [NLANES-1:0]           lane_in,
  input  logic [NUM_PORTS*PORT_W-1:0] gpio_latch,
  input  logic [NUM_PORTS*PORT_W-1:0] pad_in,
  output logic [NUM_PORTS*PORT_W-1:0] pad_out,
  output logic [NUM_PORTS*PORT_W-1:0] pad_oe,
  output logic [NUM_PORTS*PORT_W-1:0] port_rd,
  output logic                        ovf_flag
);
  localparam int NPINS = NUM_PORTS * PORT_W;
  localparam int IW    = $clog2(NLANES + NPINS + 1);

  logic [NLANES-1:0] lane_en, connected;
  logic [IW-1:0]     idx [NLANES];
  logic              overflow;

  xbar_lane_decode u_dec (
    .cfg_a(cfg_a), .cfg_b(cfg_b), .cfg_c(cfg_c), .lane_en(lane_en)
  );

  xbar_alloc #(.NPINS(NPINS), .IW(IW)) u_alloc (
    .xbar_en(xbar_en), .lane_en(lane_en), .idx(idx),
    .connected(connected), .overflow(overflow)
  );

  xbar_pad_mux #(.NPINS(NPINS), .IW(IW)) u_pad (
    .clk(clk), .rst_n(rst_n), .xbar_en(xbar_en), .connected(connected),
    .idx(idx), .lane_out(lane_out), .lane_oe(lane_oe),
    .gpio_latch(gpio_latch), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  xbar_in_route #(.NPINS(NPINS), .IW(IW)) u_in (
    .connected(connected), .idx(idx), .pad_in(pad_in), .lane_in(lane_in)
  );

  assign port_rd = pad_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_flag <= 1'b0;
    else        ovf_flag <= ovf_flag | overflow;
  end

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag |=> ovf_flag); // R9

  AST_GPIO_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (xbar_en && lane_en == '0) |=> (pad_oe == '1 && pad_out == $past(gpio_latch))); // R3

  AST_FIRST_LANE_IN: assert property (@(posedge clk) disable iff (!rst_n)
    (xbar_en && cfg_a[0]) |-> (lane_in[1] == pad_in[1])); // R7
endmodule

// File: tb/sim_pin_crossbar.sv
module sim_pin_crossbar;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [6:0]  cfg_a = '0, cfg_b = '0, cfg_c = '0;
  logic        xen = 1'b0;
  logic [30:0] lout = '0, loe = '0;
  logic [31:0] latch = '0, pin = '0;

  logic [6:0]  s_a, s_b, s_c;
  logic        s_x;
  logic [30:0] s_lout, s_loe;
  logic [31:0] s_latch, s_pin;

  logic [30:0] lin0, lin1;
  logic [31:0] pout0, poe0, prd0;
  logic [15:0] pout1, poe1, prd1;
  logic        ovf0, ovf1;

  pin_crossbar u0 (
    .clk(clk), .rst_n(rst_n), .cfg_a(cfg_a), .cfg_b(cfg_b), .cfg_c(cfg_c),
    .xbar_en(xen), .lane_out(lout), .lane_oe(loe), .lane_in(lin0),
    .gpio_latch(latch), .pad_in(pin), .pad_out(pout0), .pad_oe(poe0),
    .port_rd(prd0), .ovf_flag(ovf0)
  );

  pin_crossbar #(.NUM_PORTS(2), .PORT_W(8)) u1 (
    .clk(clk), .rst_n(rst_n), .cfg_a(cfg_a), .cfg_b(cfg_b), .cfg_c(cfg_c),
    .xbar_en(xen), .lane_out(lout), .lane_oe(loe), .lane_in(lin1),
    .gpio_latch(latch[15:0]), .pad_in(pin[15:0]), .pad_out(pout1), .pad_oe(poe1),
    .port_rd(prd1), .ovf_flag(ovf1)
  );

  int n_chk = 0, n_err = 0;
  bit done = 0;
  logic [31:0] e_out0, e_oe0, e_out1, e_oe1;
  logic        e_ovf0, e_ovf1;

  task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // behavioural reference from the requirements
  task automatic model(input int np, output logic [31:0] po, output logic [31:0] pe,
                       output logic [30:0] li, output bit ov);
    bit en [31];
    int nx, pc;
    for (int k = 0; k < 31; k++) en[k] = 0;
    en[0] = cfg_a[0]; en[1] = cfg_a[0];
    for (int i = 2; i < 6; i++) en[i] = cfg_a[1];
    en[6] = cfg_a[2]; en[7] = cfg_a[2];
    en[8] = cfg_a[3]; en[9] = cfg_a[3];
    pc = int'(cfg_a[6:4]); if (pc > 6) pc = 6;
    for (int i = 0; i < pc; i++) en[10+i] = 1;
    en[16] = cfg_b[0]; en[17] = cfg_b[0];
    for (int i = 1; i < 7; i++) en[17+i] = cfg_b[i];
    for (int i = 0; i < 7; i++) en[24+i] = cfg_c[i];
    po = '0; pe = '0; li = '1; ov = 0;
    for (int p = 0; p < np; p++) begin po[p] = latch[p]; pe[p] = 1'b1; end
    nx = 0;
    for (int k = 0; k < 31; k++) begin
      if (en[k]) begin
        if (nx < np) begin
          po[nx] = lout[k]; pe[nx] = loe[k]; li[k] = pin[nx];
        end else ov = 1;
        nx++;
      end
    end
    if (!xen) begin po = '0; pe = '0; li = '1; ov = 0; end
  endtask

  task automatic step(string tag);
    logic [31:0] po, pe; logic [30:0] li; bit ov;
    @(negedge clk);
    chk(pout0 === e_out0, tag, "u0 pad_out", 64'(pout0), 64'(e_out0));
    chk(poe0 === e_oe0, tag, "u0 pad_oe", 64'(poe0), 64'(e_oe0));
    chk(ovf0 === e_ovf0, "R9", "u0 ovf_flag", 64'(ovf0), 64'(e_ovf0));
    chk(pout1 === e_out1[15:0], tag, "u1 pad_out", 64'(pout1), 64'(e_out1[15:0]));
    chk(poe1 === e_oe1[15:0], tag, "u1 pad_oe", 64'(poe1), 64'(e_oe1[15:0]));
    chk(ovf1 === e_ovf1, "R9", "u1 ovf_flag", 64'(ovf1), 64'(e_ovf1));
    cfg_a = s_a; cfg_b = s_b; cfg_c = s_c; xen = s_x;
    lout = s_lout; loe = s_loe; latch = s_latch; pin = s_pin;
    #2;
    chk(pout0 === e_out0 && poe0 === e_oe0, "R5", "u0 pads before edge",
        {pout0, poe0}, {e_out0, e_oe0});
    chk(prd0 === pin && prd1 === pin[15:0], "R8", "port_rd", {prd1, prd0}, {pin[15:0], pin});
    model(32, po, pe, li, ov);
    chk(lin0 === li, tag, "u0 lane_in", 64'(lin0), 64'(li));
    e_out0 = po; e_oe0 = pe; e_ovf0 = e_ovf0 | ov;
    model(16, po, pe, li, ov);
    chk(lin1 === li, tag, "u1 lane_in", 64'(lin1), 64'(li));
    e_out1 = po; e_oe1 = pe; e_ovf1 = e_ovf1 | ov;
  endtask

  task automatic rnd_data();
    s_lout = 31'($urandom); s_loe = 31'($urandom);
    s_latch = $urandom; s_pin = $urandom;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    // reset state: inputs ask for outputs but reset holds pads low (R5)
    xen = 1'b1; latch = '1; lout = '1; loe = '1; cfg_a = 7'h01;
    repeat (3) @(negedge clk);
    chk(pout0 === '0 && poe0 === '0, "R5", "reset pads", {pout0, poe0}, 64'h0);
    chk(ovf0 === 1'b0 && ovf1 === 1'b0, "R5", "reset ovf", {ovf1, ovf0}, 64'h0);
    xen = 1'b0; cfg_a = '0; latch = '0; lout = '0; loe = '0;
    s_a = '0; s_b = '0; s_c = '0; s_x = 0; s_lout = '0; s_loe = '0; s_latch = '0; s_pin = '0;
    e_out0 = '0; e_oe0 = '0; e_out1 = '0; e_oe1 = '0; e_ovf0 = 0; e_ovf1 = 0;
    rst_n = 1'b1;

    // R4: everything enabled but global off
    s_a = 7'h7F; s_b = 7'h7F; s_c = 7'h7F; s_x = 0; rnd_data();
    step("R4"); step("R4");
    // R3: global on, no lanes
    s_a = '0; s_b = '0; s_c = '0; s_x = 1; rnd_data();
    step("R3"); rnd_data(); step("R3");
    // R6 / R7: UART A only, data changes with config
    s_a = 7'h01; rnd_data(); step("R6");
    rnd_data(); step("R7");
    // R1: capture count 7 clamps to 6
    s_a = 7'h70; rnd_data(); step("R1");
    s_a = 7'h30; s_b = 7'h08; rnd_data(); step("R1");
    s_a = '0; s_b = 7'h55; s_c = 7'h2A; rnd_data(); step("R2");
    // R9: exceed 16 pins on u1 while toggling global enable
    s_a = 7'h7F; s_b = 7'h7F; s_c = 7'h7F; s_x = 0; rnd_data(); step("R9");
    s_x = 1; rnd_data(); step("R9");
    s_a = 7'h01; s_b = '0; s_c = '0; rnd_data(); step("R9");
    rnd_data(); step("R9");
    // random run: config and data move together
    for (int n = 0; n < 400; n++) begin
      s_a = 7'($urandom); s_b = 7'($urandom); s_c = 7'($urandom);
      s_x = ($urandom_range(0, 7) != 0);
      rnd_data();
      step("R2");
    end
    step("R2");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule